// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a synchronous memory device. It runs a 16-state controller that advances on each rising TCK edge under TMS. A 3-bit instruction picks the register that sits between TDI and TDO. The choices are a 1-bit bypass stage, a 32-bit identification word, or a boundary chain of parameterised length. The boundary chain captures the pin values in parallel and holds an update latch for driving them.

The controller has no separate reset pin. It is cleared by the power-on reset, and it returns to its reset state after five TCK cycles with TMS high. Holding TMS high is also the result the pad pull-ups give when TMS is left open. The block also produces a decoded signal that sends the memory data pins to High-Z while an external-test or sample-with-float instruction is active. Memory array contents never enter any scan path.

Top module: `scan_tap`

## Requirements
- R1: After the power-on reset, the controller is in Test-Logic-Reset and the active instruction is 001 (identification). tdo_en is 0 and dq_hiz is 0.
- R2: From any controller state, five rising TCK edges with TMS=1 reach Test-Logic-Reset. That state restores instruction 001.
- R3: In Capture-IR the instruction shifter loads 001. Its bits leave on TDO least significant bit first, in the order 1, 0, 0.
- R4: The identification word is shifted out least significant bit first. Bit 0 is 1. Bits 11:1 are 00001001110. Bits 17:12 are the VENDOR parameter. Bits 27:18 are the PART_CFG parameter. Bits 31:28 are 0000.
- R5: Codes 011, 101, 110 and 111 select the 1-bit bypass stage. It captures 0, so TDO shows 0 first and then each TDI bit one shift later.
- R6: Codes 000, 010 and 100 select the boundary chain. Capture-DR loads bsr_pin_in, which shifts out from bit 0 first. Update-DR copies the shifted-in value to bsr_upd, and bsr_upd changes at no other time.
- R7: dq_hiz is 1 exactly when the active instruction is 000 or 010. It is 0 for code 100 and for all other codes.
- R8: tdo_en is 1 only while the controller is in Shift-IR or Shift-DR. tdo_en and TDO change on the falling TCK edge.
- R9: Once Shift-DR is left through Exit1, Pause and Exit2, the bypass stage keeps the last shifted TDI bit. That bit is the first TDO value on re-entry to Shift-DR.
- R10: The active instruction, and therefore dq_hiz, changes only in Update-IR or Test-Logic-Reset, and not while a new code is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bsr_pin_in | input | BSR_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for tdo |
| dq_hiz | output | 1 | Forces the memory data pins to High-Z |
| bsr_upd | output | BSR_LEN | Boundary update latch |

## Verification
Every one of the eight instruction codes is loaded, and the register it connects is checked by shifting a known pattern through it. A wrong decode therefore shows up as the wrong scan length or the wrong captured value. The bench walks all 16 four-step TMS prefixes before forcing reset, so a mistake in any transition would leave the identification read misaligned. A float control tied to the shifter instead of the active instruction would flip dq_hiz in Exit1-IR. A bypass stage that re-cleared outside Capture-DR would return 0 instead of the held bit after a pause.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_LEN  = 74,
  parameter logic [9:0]  PART_CFG = 10'b0100000100,
  parameter logic [5:0]  VENDOR   = 6'b000000
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_pin_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic               dq_hiz,
  output logic [BSR_LEN-1:0] bsr_upd
);
  localparam logic [31:0] ID_WORD = {4'b0000, PART_CFG, VENDOR, 11'b00001001110, 1'b1};
  localparam logic [2:0]  OP_ID   = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PS_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PS_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t st, st_nx;
  logic [2:0]         ir, ir_sh;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic               byp;
  logic               sel_bsr, sel_id;
  logic               dr_bit;

  always_comb begin
    case (st)
      TLR:     st_nx = tms ? TLR    : RTI;
      RTI:     st_nx = tms ? SEL_DR : RTI;
      SEL_DR:  st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_nx = tms ? UPD_DR : PS_DR;
      PS_DR:   st_nx = tms ? EX2_DR : PS_DR;
      EX2_DR:  st_nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  st_nx = tms ? SEL_DR : RTI;
      SEL_IR:  st_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_nx = tms ? UPD_IR : PS_IR;
      PS_IR:   st_nx = tms ? EX2_IR : PS_IR;
      EX2_IR:  st_nx = tms ? UPD_IR : SH_IR;
      UPD_IR:  st_nx = tms ? SEL_DR : RTI;
      default: st_nx = TLR;
    endcase
  end

  assign sel_id  = (ir == OP_ID);
  assign sel_bsr = (ir == 3'b000) || (ir == 3'b010) || (ir == 3'b100);
  assign dq_hiz  = (ir == 3'b000) || (ir == 3'b010);
  assign dr_bit  = sel_id ? id_sh[0] : sel_bsr ? bsr_sh[0] : byp;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      st      <= TLR;
      ir      <= OP_ID;
      ir_sh   <= 3'b001;
      id_sh   <= '0;
      bsr_sh  <= '0;
      byp     <= 1'b0;
      bsr_upd <= '0;
    end else begin
      st <= st_nx;
      case (st)
        TLR:    ir <= OP_ID;
        CAP_IR: ir_sh <= 3'b001;
        SH_IR:  ir_sh <= {tdi, ir_sh[2:1]};
        UPD_IR: ir <= ir_sh;
        CAP_DR: begin
          if (sel_id)  id_sh  <= ID_WORD;
          if (sel_bsr) bsr_sh <= bsr_pin_in;
          if (!sel_id && !sel_bsr) byp <= 1'b0;
        end
        SH_DR: begin
          if (sel_id)  id_sh  <= {tdi, id_sh[31:1]};
          if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
          if (!sel_id && !sel_bsr) byp <= tdi;
        end
        UPD_DR: if (sel_bsr) bsr_upd <= bsr_sh;
        default: ;
      endcase
    end

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == SH_IR) ? ir_sh[0] : dr_bit;
      tdo_en <= (st == SH_IR) || (st == SH_DR);
    end

  a_r2_tlr_holds: assert property (@(posedge tck) disable iff (!por_n)
    (st == TLR && tms) |=> (st == TLR));
  a_r1_tlr_idcode: assert property (@(posedge tck) disable iff (!por_n)
    (st == TLR) |=> (ir == OP_ID));
  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!por_n)
    (st == CAP_IR) |=> (ir_sh == 3'b001));
  a_r10_ir_stable: assert property (@(posedge tck) disable iff (!por_n)
    (st != UPD_IR && st != TLR) |=> $stable(ir));
  a_r6_upd_stable: assert property (@(posedge tck) disable iff (!por_n)
    (st != UPD_DR) |=> $stable(bsr_upd));
  a_r8_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (st == SH_IR || st == SH_DR));
endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;
  localparam int         N   = 12;
  localparam logic [9:0] CFG = 10'b0100000100;
  localparam logic [5:0] VEN = 6'b101010;
  localparam logic [31:0] EXP_ID = {4'b0000, CFG, VEN, 11'b00001001110, 1'b1};

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [N-1:0] pins = '0;
  logic tdo, tdo_en, dq_hiz;
  logic [N-1:0] bsr_upd;
  int checks = 0, fails = 0;

  scan_tap #(.BSR_LEN(N), .PART_CFG(CFG), .VENDOR(VEN)) u0 (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bsr_pin_in(pins),
    .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz), .bsr_upd(bsr_upd));

  always #2 tck = ~tck;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output logic hiz_mid);
    step(1, 1); step(1, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    hiz_mid = dq_hiz;
    step(1, 1); step(0, 1);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output logic en_seen);
    dout = '0;
    step(1, 1); step(0, 1); step(0, 1);
    en_seen = tdo_en;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 1); step(0, 1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] cap;
    logic hm, en;
    logic [63:0] q;
    logic prev_hiz;
    #5 por_n = 1'b1;
    @(negedge tck); #1;
    chk(tdo_en == 1'b0, "R1 tdo_en after reset", {63'd0, tdo_en}, 64'd0);
    chk(dq_hiz == 1'b0, "R1 dq_hiz after reset", {63'd0, dq_hiz}, 64'd0);
    step(0, 1);
    scan_dr(32, 64'd0, q, en);
    chk(q[31:0] == EXP_ID, "R1 R4 idcode after reset", q, {32'd0, EXP_ID});
    chk(en == 1'b1, "R8 tdo_en in Shift-DR", {63'd0, en}, 64'd1);
    chk(tdo_en == 1'b0, "R8 tdo_en in Run-Test-Idle", {63'd0, tdo_en}, 64'd0);

    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 4; b++) step(k[b], b[0]);
      for (int r = 0; r < 5; r++) step(1, 1);
      step(0, 1);
      scan_dr(32, 64'd0, q, en);
      chk(q[31:0] == EXP_ID, $sformatf("R2 reset after prefix %0d", k), q, {32'd0, EXP_ID});
    end

    prev_hiz = dq_hiz;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code = 3'(c);
      logic exp_hiz = (code == 3'b000) || (code == 3'b010);
      load_ir(code, cap, hm);
      chk(cap == 3'b001, "R3 captured IR", {61'd0, cap}, 64'd1);
      chk(hm == prev_hiz, "R10 dq_hiz held in Exit1-IR", {63'd0, hm}, {63'd0, prev_hiz});
      chk(dq_hiz == exp_hiz, $sformatf("R7 dq_hiz code %0d", c), {63'd0, dq_hiz}, {63'd0, exp_hiz});
      prev_hiz = dq_hiz;
      if (code == 3'b001) begin
        scan_dr(32, 64'd0, q, en);
        chk(q[31:0] == EXP_ID, "R4 idcode via IR", q, {32'd0, EXP_ID});
      end else if (code == 3'b000 || code == 3'b010 || code == 3'b100) begin
        logic [N-1:0] p = N'(12'hA5C ^ (c * 12'h111));
        logic [N-1:0] din = ~p ^ N'(c);
        pins = p;
        scan_dr(N, {{(64-N){1'b0}}, din}, q, en);
        chk(q[N-1:0] == p, $sformatf("R6 boundary capture code %0d", c), q, {{(64-N){1'b0}}, p});
        chk(bsr_upd == din, $sformatf("R6 boundary update code %0d", c), {{(64-N){1'b0}}, bsr_upd}, {{(64-N){1'b0}}, din});
      end else begin
        logic [7:0] d = 8'(8'h9B + c * 37);
        logic [N-1:0] held = bsr_upd;
        logic [7:0] exp8 = {d[6:0], 1'b0};
        scan_dr(8, {56'd0, d}, q, en);
        chk(q[7:0] == exp8, $sformatf("R5 bypass code %0d", c), q, {56'd0, exp8});
        chk(bsr_upd == held, "R6 update latch unchanged under bypass", {{(64-N){1'b0}}, bsr_upd}, {{(64-N){1'b0}}, held});
      end
    end

    for (int b = 0; b < 2; b++) begin
      logic bit_in = b[0];
      step(1, 1); step(0, 1); step(0, 1);
      step(1, bit_in);
      step(0, 1);
      chk(tdo_en == 1'b0, "R8 tdo_en in Pause-DR", {63'd0, tdo_en}, 64'd0);
      step(1, 1); step(0, 1);
      chk(tdo == bit_in, "R9 bypass holds bit across pause", {63'd0, tdo}, {63'd0, bit_in});
      step(1, 1); step(1, 1); step(0, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule